// File: doc/BRIEF.md
# Asynchronous Serial Framer

This block is the datapath of a single asynchronous serial channel. A baud generator divides the system clock by a programmable 16-bit divisor and produces one enable tick per 1/16 of a bit time. The transmitter takes bytes from a 64-entry queue and shifts them out on `txd`. Each frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and a high stop period. The receiver oversamples `rxd` and rebuilds characters. It stores each one, with its parity, framing and break flags, in a 64-entry receive queue.

The frame format comes from plain control inputs: character length, parity mode and a long-stop select. Status outputs give the level of both queues, a programmable receive trigger, a receive overflow pulse, a transmit underrun pulse and an idle-line indication. The host logic writes `tx_wr`/`tx_data` and pops received entries with `rx_rd`. The receive head entry always appears on `rx_data` and the flag outputs.

Top module: `uart_framer`

## Requirements
- R1: After reset `txd` is 1, both queues report level 0, and `rx_empty` is 1.
- R2: A transmitted frame is a low start bit, then `cfg_wlen`+5 data bits with bit 0 first, then a parity bit if enabled, then a high stop period. Each bit lasts 16 ticks, and a tick comes every `divisor` clocks. `cfg_par` selects the parity: 2'b01 gives odd parity, 2'b10 gives even parity (data ones plus parity bit is even), and 2'b00 or 2'b11 gives none.
- R3: With `cfg_stop_long`=0 the stop period is 16 ticks. With `cfg_stop_long`=1 it is 24 ticks when `cfg_wlen`=0 (5 bits) and 32 ticks otherwise.
- R4: A received frame is stored with its data bits in the low positions and the unused upper bits at 0. Entries leave the queue in arrival order.
- R5: A parity bit that disagrees with the selected parity sets `rx_pe` on that entry.
- R6: A stop bit sampled low on a frame with some nonzero bit sets `rx_fe` on that entry.
- R7: If the start bit, all data bits, any parity bit and the stop bit all sample low, exactly one entry is stored. That entry has data 0, `rx_brk`=1 and `rx_pe`=`rx_fe`=0. No further entry is stored until the line returns high.
- R8: A low pulse that has ended before the mid-point of the start bit (the 8th tick) stores nothing.
- R9: When a frame arrives with the receive queue holding 64 entries, it is dropped, the level stays at 64, and `rx_ovf` pulses for one cycle.
- R10: `rx_trig_hit` is 1 exactly when `rx_trig` is nonzero and `rx_level` >= `rx_trig`.
- R11: `rx_idle` rises once the receiver has been waiting for a start bit for 4 frame times with the receive queue non-empty. A frame time counts 1.5 stop bits as 2. `rx_idle` clears when the queue empties or a start bit arrives.
- R12: `tx_urun` pulses for one cycle, with `txd` high, when a frame's stop period ends and the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 16 | Clocks per oversampling tick (0 stops the ticks) |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_par | input | 2 | Parity mode: 01 odd, 10 even, others none |
| cfg_stop_long | input | 1 | Long stop period (1.5 bits for 5-bit characters, else 2) |
| rx_trig | input | 7 | Receive trigger level, 0 disables |
| tx_wr | input | 1 | Push `tx_data` into the transmit queue (ignored when full) |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_level | output | 7 | Transmit queue occupancy |
| tx_urun | output | 1 | Underrun pulse at end of frame with empty queue |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_rd | input | 1 | Pop the receive head entry |
| rx_data | output | 8 | Receive head data |
| rx_pe | output | 1 | Head entry parity error |
| rx_fe | output | 1 | Head entry framing error |
| rx_brk | output | 1 | Head entry is a break |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | 7 | Receive queue occupancy |
| rx_trig_hit | output | 1 | Receive level at or above trigger |
| rx_ovf | output | 1 | One-cycle pulse: frame dropped on full queue |
| rx_idle | output | 1 | Idle line with data waiting |

## Verification
The properties assume that the frame controls and the divisor stay constant while a frame is in flight. Otherwise the stop-period and parity relations lose their meaning. The bench changes them only after the transmitter has signalled its underrun and the receiver has finished its last frame. The properties also assume that `rxd` holds each level for whole bit times when a frame is meant to be decoded. The bench drives its own frames with bit periods of exactly 16 divisor tick spans and returns the line high between frames. The only sub-bit pulse it drives is the deliberate false start.

// File: rtl/uart_fr_pkg.sv
package uart_fr_pkg;

    localparam int OSR = 16;

    typedef struct packed {
        logic [1:0] wlen;
        logic [1:0] par;
        logic       stop_long;
    } fr_cfg_t;

    typedef struct packed {
        logic       brk;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rx_ent_t;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_st_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD} rx_st_t;

    // index of the final data bit of a character
    function automatic logic [2:0] last_bit(input logic [1:0] w);
        return 3'd4 + {1'b0, w};
    endfunction

    function automatic logic [7:0] len_mask(input logic [1:0] w);
        return 8'hFF >> (2'd3 - w);
    endfunction

    function automatic logic par_used(input logic [1:0] p);
        return (p == 2'b01) || (p == 2'b10);
    endfunction

    function automatic logic par_of(input logic [7:0] d, input fr_cfg_t c);
        return (^(d & len_mask(c.wlen))) ^ (c.par == 2'b01);
    endfunction

    function automatic logic [5:0] stop_len(input fr_cfg_t c);
        if (!c.stop_long) return 6'd16;
        if (c.wlen == 2'd0) return 6'd24;
        return 6'd32;
    endfunction

    // four frame times in ticks (bits * 16 * 4)
    function automatic logic [11:0] idle_lim(input fr_cfg_t c);
        logic [3:0] b;
        b = 4'd7 + {2'b00, c.wlen} + {3'b000, par_used(c.par)} + {3'b000, c.stop_long};
        return {2'b00, b, 6'b000000};
    endfunction

endpackage

// File: rtl/uart_fr_baud.sv
module uart_fr_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (divisor == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= divisor - 1'b1) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_fr_fifo.sv
module uart_fr_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/uart_fr_tx.sv
module uart_fr_tx
    import uart_fr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  fr_cfg_t    cfg,
    input  logic       f_empty,
    input  logic [7:0] f_data,
    output logic       pop,
    output logic       txd,
    output logic       urun
);
    tx_st_t     st;
    logic [5:0] tcnt;
    logic [7:0] sh;
    logic [2:0] bidx;
    logic       pbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= TX_IDLE;
            txd  <= 1'b1;
            tcnt <= '0;
            sh   <= '0;
            bidx <= '0;
            pbit <= 1'b0;
            pop  <= 1'b0;
            urun <= 1'b0;
        end else begin
            pop  <= 1'b0;
            urun <= 1'b0;
            if (tick) begin
                case (st)
                    TX_IDLE: if (!f_empty) begin
                        pop  <= 1'b1;
                        sh   <= f_data;
                        pbit <= par_of(f_data, cfg);
                        txd  <= 1'b0;
                        tcnt <= '0;
                        st   <= TX_START;
                    end
                    TX_START: if (tcnt == 6'd15) begin
                        tcnt <= '0;
                        txd  <= sh[0];
                        bidx <= '0;
                        st   <= TX_DATA;
                    end else tcnt <= tcnt + 1'b1;
                    TX_DATA: if (tcnt == 6'd15) begin
                        tcnt <= '0;
                        if (bidx == last_bit(cfg.wlen)) begin
                            if (par_used(cfg.par)) begin
                                txd <= pbit;
                                st  <= TX_PAR;
                            end else begin
                                txd <= 1'b1;
                                st  <= TX_STOP;
                            end
                        end else begin
                            bidx <= bidx + 1'b1;
                            sh   <= sh >> 1;
                            txd  <= sh[1];
                        end
                    end else tcnt <= tcnt + 1'b1;
                    TX_PAR: if (tcnt == 6'd15) begin
                        tcnt <= '0;
                        txd  <= 1'b1;
                        st   <= TX_STOP;
                    end else tcnt <= tcnt + 1'b1;
                    TX_STOP: if (tcnt == stop_len(cfg) - 6'd1) begin
                        tcnt <= '0;
                        st   <= TX_IDLE;
                        urun <= f_empty;
                    end else tcnt <= tcnt + 1'b1;
                    default: st <= TX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_fr_rx.sv
module uart_fr_rx
    import uart_fr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  fr_cfg_t cfg,
    input  logic    rxd,
    input  logic    f_empty,
    output logic    push,
    output rx_ent_t ent,
    output logic    idle
);
    rx_st_t      st;
    logic        s1, s2;
    logic [3:0]  cnt;
    logic [2:0]  bidx;
    logic [7:0]  sh;
    logic        allz, pbit;
    logic [11:0] icnt;
    logic        brk_now, pe_now;

    assign brk_now = allz & ~s2;
    assign pe_now  = par_used(cfg.par) & (pbit != par_of(sh, cfg));
    assign idle    = (icnt == idle_lim(cfg));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            bidx <= '0;
            sh   <= '0;
            allz <= 1'b0;
            pbit <= 1'b0;
            push <= 1'b0;
            ent  <= '0;
        end else begin
            push <= 1'b0;
            case (st)
                RX_IDLE: if (tick && !s2) begin
                    st  <= RX_START;
                    cnt <= '0;
                end
                RX_START: if (tick) begin
                    if (cnt == 4'd7) begin
                        if (s2) st <= RX_IDLE;
                        else begin
                            st   <= RX_DATA;
                            cnt  <= '0;
                            bidx <= '0;
                            sh   <= '0;
                            allz <= 1'b1;
                        end
                    end else cnt <= cnt + 1'b1;
                end
                RX_DATA: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == 4'd15) begin
                        sh[bidx] <= s2;
                        allz     <= allz & ~s2;
                        if (bidx == last_bit(cfg.wlen))
                            st <= par_used(cfg.par) ? RX_PAR : RX_STOP;
                        else
                            bidx <= bidx + 1'b1;
                    end
                end
                RX_PAR: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == 4'd15) begin
                        pbit <= s2;
                        allz <= allz & ~s2;
                        st   <= RX_STOP;
                    end
                end
                RX_STOP: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == 4'd15) begin
                        push     <= 1'b1;
                        ent.brk  <= brk_now;
                        ent.fe   <= ~brk_now & ~s2;
                        ent.pe   <= ~brk_now & pe_now;
                        ent.data <= brk_now ? 8'h00 : sh;
                        st       <= s2 ? RX_IDLE : RX_HOLD;
                    end
                end
                RX_HOLD: if (s2) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end

    // idle-line timer: runs only while waiting for a start with data queued
    always_ff @(posedge clk) begin
        if (rst || st != RX_IDLE || f_empty || (tick && !s2))
            icnt <= '0;
        else if (tick && icnt < idle_lim(cfg))
            icnt <= icnt + 1'b1;
    end
endmodule

// File: rtl/uart_framer.sv
module uart_framer
    import uart_fr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DIV_W = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic [1:0]       cfg_wlen,
    input  logic [1:0]       cfg_par,
    input  logic             cfg_stop_long,
    input  logic [LW-1:0]    rx_trig,
    input  logic             tx_wr,
    input  logic [7:0]       tx_data,
    output logic             tx_full,
    output logic [LW-1:0]    tx_level,
    output logic             tx_urun,
    output logic             txd,
    input  logic             rxd,
    input  logic             rx_rd,
    output logic [7:0]       rx_data,
    output logic             rx_pe,
    output logic             rx_fe,
    output logic             rx_brk,
    output logic             rx_empty,
    output logic [LW-1:0]    rx_level,
    output logic             rx_trig_hit,
    output logic             rx_ovf,
    output logic             rx_idle
);
    fr_cfg_t    cfg;
    logic       baud_tick;
    logic       txf_empty, tx_pop;
    logic [7:0] txf_head;
    logic       rx_push, rx_full;
    rx_ent_t    rx_in, rx_head;

    assign cfg = '{wlen: cfg_wlen, par: cfg_par, stop_long: cfg_stop_long};

    uart_fr_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .divisor(divisor), .tick(baud_tick)
    );

    uart_fr_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_wr), .din(tx_data), .pop(tx_pop),
        .dout(txf_head), .full(tx_full), .empty(txf_empty), .level(tx_level)
    );

    uart_fr_tx u_tx (
        .clk(clk), .rst(rst), .tick(baud_tick), .cfg(cfg), .f_empty(txf_empty),
        .f_data(txf_head), .pop(tx_pop), .txd(txd), .urun(tx_urun)
    );

    uart_fr_rx u_rx (
        .clk(clk), .rst(rst), .tick(baud_tick), .cfg(cfg), .rxd(rxd),
        .f_empty(rx_empty), .push(rx_push), .ent(rx_in), .idle(rx_idle)
    );

    uart_fr_fifo #(.W($bits(rx_ent_t)), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_in), .pop(rx_rd),
        .dout(rx_head), .full(rx_full), .empty(rx_empty), .level(rx_level)
    );

    assign rx_data     = rx_head.data;
    assign rx_pe       = rx_head.pe;
    assign rx_fe       = rx_head.fe;
    assign rx_brk      = rx_head.brk;
    assign rx_trig_hit = (rx_trig != '0) && (rx_level >= rx_trig);

    always_ff @(posedge clk) begin
        if (rst) rx_ovf <= 1'b0;
        else     rx_ovf <= rx_push & rx_full;
    end
endmodule

// File: rtl/uart_framer_sva.sv
module uart_framer_sva #(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          baud_tick,
    input logic          txd,
    input logic [LW-1:0] tx_level,
    input logic          tx_urun,
    input logic [LW-1:0] rx_level,
    input logic          rx_empty,
    input logic          rx_brk,
    input logic [7:0]    rx_data,
    input logic          rx_ovf,
    input logic          rx_idle
);
    // R2: the serial line only moves on an oversampling tick
    p_txd_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> $past(baud_tick));

    // R2: the transmit queue moves by at most one entry per cycle
    p_txlvl_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_level == $past(tx_level)) || (tx_level == $past(tx_level) + 1'b1)
        || (tx_level + 1'b1 == $past(tx_level)));

    p_level_cap_r9: assert property (@(posedge clk) disable iff (rst)
        rx_level <= LW'(DEPTH));

    p_ovf_at_full_r9: assert property (@(posedge clk) disable iff (rst)
        rx_ovf |-> $past(rx_level) == LW'(DEPTH));

    p_break_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (!rx_empty && rx_brk) |-> rx_data == 8'h00);

    p_idle_has_data_r11: assert property (@(posedge clk) disable iff (rst)
        rx_idle |-> $past(rx_level) != '0);

    p_urun_line_high_r12: assert property (@(posedge clk) disable iff (rst)
        tx_urun |-> txd);
endmodule

bind uart_framer uart_framer_sva #(.DEPTH(DEPTH)) u_sva (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .txd(txd), .tx_level(tx_level),
    .tx_urun(tx_urun), .rx_level(rx_level), .rx_empty(rx_empty), .rx_brk(rx_brk),
    .rx_data(rx_data), .rx_ovf(rx_ovf), .rx_idle(rx_idle)
);

// File: tb/sim_uart_framer.sv
module sim_uart_framer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [15:0] divr = 16'd2;
    logic [1:0]  wl = 2'd3, pm = 2'd0;
    logic        sl = 1'b0;
    logic [6:0]  trig = 7'd0;
    logic        tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        lb = 1'b1, rx_drv = 1'b1;
    logic        tx_full, tx_urun, txd, rx_pe, rx_fe, rx_brk, rx_empty, rx_trig_hit, rx_ovf, rx_idle;
    logic [6:0]  tx_level, rx_level;
    logic [7:0]  rx_data;
    logic        rxd_w;

    assign rxd_w = lb ? txd : rx_drv;

    uart_framer u0 (
        .clk(clk), .rst(rst), .divisor(divr), .cfg_wlen(wl), .cfg_par(pm),
        .cfg_stop_long(sl), .rx_trig(trig), .tx_wr(tx_wr), .tx_data(tx_data),
        .tx_full(tx_full), .tx_level(tx_level), .tx_urun(tx_urun), .txd(txd),
        .rxd(rxd_w), .rx_rd(rx_rd), .rx_data(rx_data), .rx_pe(rx_pe), .rx_fe(rx_fe),
        .rx_brk(rx_brk), .rx_empty(rx_empty), .rx_level(rx_level),
        .rx_trig_hit(rx_trig_hit), .rx_ovf(rx_ovf), .rx_idle(rx_idle)
    );

    int checks = 0, errors = 0, urun_cnt = 0, ovf_cnt = 0, cyc = 0;
    logic [7:0] tx_q[$];
    bit frm[$];
    bit active = 0;
    int t = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] msk();
        return 8'hFF >> (2'd3 - wl);
    endfunction

    function automatic bit parity(input logic [7:0] d);
        return (^(d & msk())) ^ (pm == 2'b01);
    endfunction

    function automatic bit par_on();
        return pm == 2'b01 || pm == 2'b10;
    endfunction

    function automatic void add_seg(input bit lvl, input int ticks);
        for (int i = 0; i < ticks * int'(divr); i++) frm.push_back(lvl);
    endfunction

    // expected line levels, one per clock, for a whole frame (R2 R3)
    function automatic void build(input logic [7:0] d);
        frm.delete();
        add_seg(1'b0, 16);
        for (int i = 0; i < 5 + int'(wl); i++) add_seg(d[i], 16);
        if (par_on()) add_seg(parity(d), 16);
        add_seg(1'b1, !sl ? 16 : (wl == 2'd0 ? 24 : 32));
    endfunction

    // per-clock reference of the serial output
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_urun) urun_cnt++;
            if (rx_ovf) ovf_cnt++;
            if (active) begin
                chk(txd == frm[t], "R2 R3 txd level", int'(txd), int'(frm[t]));
                t++;
                if (t == frm.size()) active = 0;
            end else if (txd == 1'b0) begin
                if (tx_q.size() == 0) chk(1'b0, "R2 unexpected start", 0, 1);
                else begin
                    build(tx_q.pop_front());
                    checks++;
                    t = 1;
                    active = 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_data = d;
        tx_q.push_back(d & msk());
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic wait_urun();
        int u0v = urun_cnt;
        while (urun_cnt == u0v) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [7:0] d, input bit pe, input bit fe, input bit brk, input string req);
        @(negedge clk);
        chk(!rx_empty && rx_data == d && rx_pe == pe && rx_fe == fe && rx_brk == brk, req,
            {rx_empty, rx_brk, rx_fe, rx_pe, rx_data}, {1'b0, brk, fe, pe, d});
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic drive_frame(input logic [7:0] d, input bit pbit, input bit stopv);
        int bp = 16 * int'(divr);
        rx_drv = 1'b0;
        repeat (bp) @(negedge clk);
        for (int i = 0; i < 5 + int'(wl); i++) begin
            rx_drv = d[i];
            repeat (bp) @(negedge clk);
        end
        if (par_on()) begin
            rx_drv = pbit;
            repeat (bp) @(negedge clk);
        end
        rx_drv = stopv;
        repeat (bp) @(negedge clk);
        rx_drv = 1'b1;
        repeat (2 * bp) @(negedge clk);
    endtask

    initial begin
        int cw[5] = '{3, 0, 2, 1, 3};
        int cp[5] = '{0, 2, 1, 0, 2};
        int cs[5] = '{0, 1, 1, 0, 1};
        logic [7:0] bytes[3] = '{8'hA5, 8'h3C, 8'h96};
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1 && rx_empty && rx_level == 0 && tx_level == 0, "R1 reset",
            {txd, rx_empty, rx_level, tx_level}, {1'b1, 1'b1, 7'd0, 7'd0});

        // R2 R3 R4 R12: loopback over several formats
        for (int c = 0; c < 5; c++) begin
            int u_before;
            wl = cw[c][1:0]; pm = cp[c][1:0]; sl = cs[c][0];
            u_before = urun_cnt;
            for (int k = 0; k < 3; k++) send(bytes[k] ^ 8'(c));
            wait_urun();
            chk(urun_cnt == u_before + 1, "R12 underrun pulse", urun_cnt - u_before, 1);
            chk(rx_level == 3, "R4 entry count", int'(rx_level), 3);
            for (int k = 0; k < 3; k++)
                rd_chk((bytes[k] ^ 8'(c)) & msk(), 1'b0, 1'b0, 1'b0, "R4 loopback data");
        end

        // R5 parity error, 8 bits even parity
        lb = 1'b0; wl = 2'd3; pm = 2'b10; sl = 1'b0;
        repeat (10) @(negedge clk);
        drive_frame(8'h01, 1'b0, 1'b1);
        rd_chk(8'h01, 1'b1, 1'b0, 1'b0, "R5 parity error");
        drive_frame(8'h03, 1'b0, 1'b1);
        rd_chk(8'h03, 1'b0, 1'b0, 1'b0, "R5 good parity");

        // R6 framing error
        drive_frame(8'h55, 1'b0, 1'b0);
        rd_chk(8'h55, 1'b0, 1'b1, 1'b0, "R6 framing error");

        // R7 break: line low for 14 bit times
        rx_drv = 1'b0;
        repeat (14 * 16 * int'(divr)) @(negedge clk);
        rx_drv = 1'b1;
        repeat (64) @(negedge clk);
        chk(rx_level == 1, "R7 single break entry", int'(rx_level), 1);
        rd_chk(8'h00, 1'b0, 1'b0, 1'b1, "R7 break entry");

        // R8 false start shorter than half a bit
        rx_drv = 1'b0;
        repeat (3 * int'(divr)) @(negedge clk);
        rx_drv = 1'b1;
        repeat (20 * 16 * int'(divr)) @(negedge clk);
        chk(rx_empty && rx_level == 0, "R8 false start ignored", int'(rx_level), 0);

        // R11 idle after four frame times (8N1: 640 ticks)
        divr = 16'd1; pm = 2'b00;
        repeat (10) @(negedge clk);
        drive_frame(8'h42, 1'b0, 1'b1);
        repeat (300) @(negedge clk);
        chk(rx_idle == 1'b0, "R11 idle not yet", int'(rx_idle), 0);
        repeat (500) @(negedge clk);
        chk(rx_idle == 1'b1, "R11 idle raised", int'(rx_idle), 1);
        rd_chk(8'h42, 1'b0, 1'b0, 1'b0, "R11 idle data");
        @(negedge clk);
        chk(rx_idle == 1'b0, "R11 idle cleared on empty", int'(rx_idle), 0);

        // R9 R10 overflow and trigger
        lb = 1'b1; trig = 7'd32;
        repeat (10) @(negedge clk);
        chk(rx_trig_hit == 1'b0, "R10 trigger below", int'(rx_trig_hit), 0);
        for (int i = 0; i < 33; i++) send(8'(i * 7 + 3));
        wait_urun();
        chk(rx_trig_hit == 1'b1 && rx_level == 33, "R10 trigger reached", int'(rx_level), 33);
        for (int i = 33; i < 66; i++) send(8'(i * 7 + 3));
        wait_urun();
        chk(rx_level == 64, "R9 level capped", int'(rx_level), 64);
        chk(ovf_cnt == 2, "R9 overflow pulses", ovf_cnt, 2);
        for (int i = 0; i < 33; i++) rd_chk(8'(i * 7 + 3), 1'b0, 1'b0, 1'b0, "R9 kept order");
        @(negedge clk);
        chk(rx_level == 31 && rx_trig_hit == 1'b0, "R10 trigger dropped", int'(rx_trig_hit), 0);
        for (int i = 33; i < 64; i++) rd_chk(8'(i * 7 + 3), 1'b0, 1'b0, 1'b0, "R9 kept order");
        @(negedge clk);
        chk(rx_empty == 1'b1, "R9 dropped frames absent", int'(rx_level), 0);
        trig = 7'd0;
        @(negedge clk);
        chk(rx_trig_hit == 1'b0, "R10 trigger disabled", int'(rx_trig_hit), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule